// File: doc/BRIEF.md
# Event Trailer Error Status Aggregator

This block gathers the error and warning pulses raised by detectors elsewhere in a readout data path while an event is being built, and condenses them into a 32-bit status word for the event trailer, together with two 15-bit masks that name which inputs showed an error and which showed a warning. The detectors are outside the block. It only sees one pulse line per condition, one input-error and one input-warning strobe that share an input index, the event start and event end strobes, and a level that reports that the downstream consumer is asking the path to wait.

Conditions fall into classes. Reset-required conditions latch and survive event boundaries until the synchronous reset. All other conditions are accumulated per event and dropped at the next event start. Four summary bits are formed as ORs over classes. On the event-end strobe the word and both masks are captured into output registers. These hold until the next event end, so the trailer writer can read them at leisure.

Top module: `errstat_agg`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output and all accumulated state clear to zero, including the reset-required conditions.
- R2: Source bits 7:0 (the reset-required class) stay set from the event in which they were pulsed through every later event until a reset.
- R3: Source bits 27:8 cover only the current event: each is cleared at `evt_start`. A pulse in the same cycle as `evt_start` counts for the new event, and a pulse between an event end and the next start is discarded.
- R4: Status bit 28 (critical summary) is the OR of status bits 7:0.
- R5: Status bit 29 (bad-event summary) is the OR of the bad-event class, status bits 19:8.
- R6: Status bit 30 (warning summary) is the OR of the two warning conditions, status bits 21:20.
- R7: Status bit 31 (near-full summary) is the OR of the near-full conditions, status bits 23:22, and of `dn_wait` as sampled in the `evt_end` cycle. Bits 27:24 are status-only and feed no summary.
- R8: The status word is captured on `evt_end` and appears on the output in the following cycle. It includes pulses that arrive in the `evt_end` cycle and is held unchanged until the next `evt_end`.
- R9: `in_err_hit` sets bit `in_idx` of the input-error mask, and `in_warn_hit` does the same for the input-warning mask. Both masks are per event and clear at `evt_start`. An index of 15 or more has no effect.
- R10: Both masks are captured with the status word on `evt_end`, including hits in that cycle, and hold until the next `evt_end`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_start | input | 1 | Event start strobe |
| evt_end | input | 1 | Event end strobe, captures the snapshot |
| src_pulse | input | 28 | One pulse line per error or warning condition |
| dn_wait | input | 1 | Downstream wait level |
| in_err_hit | input | 1 | An input showed an error this cycle |
| in_warn_hit | input | 1 | An input showed a warning this cycle |
| in_idx | input | 4 | Input index for the hit strobes |
| trl_status | output | 32 | Captured trailer status word |
| in_err_mask | output | 15 | Captured per-input error mask |
| in_warn_mask | output | 15 | Captured per-input warning mask |

## Verification
The hardest case to reach is the point where a reset-required condition and per-event conditions from different events overlap in one snapshot. This requires the class split to survive many event boundaries. The stimulus sweeps every source bit alone, one event per bit, without resetting in between. As a result, later snapshots carry the whole growing set of latched bits next to a single fresh per-event bit, and the bench checks each summary against the set it expects. Pulses placed in the start cycle, in the end cycle and in the gap between events cover the boundaries. Hold cycles with live pulses but no end strobe show that the captured word does not move.

// File: rtl/errstat_pkg.sv
// Package: class sizes and layout of the trailer status word.
package errstat_pkg;
    localparam int N_STICKY_D = 8;   // reset-required conditions
    localparam int N_BAD_D    = 12;  // bad-event conditions
    localparam int N_WARN_D   = 2;   // warning conditions
    localparam int N_NFULL_D  = 2;   // near-full conditions
    localparam int N_INFO_D   = 4;   // status-only conditions
    localparam int N_SUM      = 4;   // summary bits above the sources
    localparam int N_IN_D     = 15;  // number of inputs
    localparam int IDX_W_D    = 4;   // input index width

    // Summary bit positions, relative to the first summary bit.
    localparam int SUM_CRIT  = 0;
    localparam int SUM_BAD   = 1;
    localparam int SUM_WARN  = 2;
    localparam int SUM_NFULL = 3;
endpackage

// File: rtl/errstat_src_accum.sv
// Module: errstat_src_accum
// Accumulates condition pulses. Bits below N_STICKY persist until reset,
// the rest are restarted by evt_start (a pulse in that cycle is kept).
// Assumes: synchronous active-low reset; pulses are single-cycle or level.
module errstat_src_accum #(
    parameter int N_SRC    = 28,
    parameter int N_STICKY = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_start,
    input  logic [N_SRC-1:0] pulse,
    output logic [N_SRC-1:0] acc_q,
    output logic [N_SRC-1:0] acc_now
);
    // Current view including this cycle's pulses, used by the snapshot.
    assign acc_now = acc_q | pulse;

    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        if (i < N_STICKY) begin : g_sticky
            // Latch the condition until reset.
            always_ff @(posedge clk) begin
                if (!rst_n) acc_q[i] <= 1'b0;
                else        acc_q[i] <= acc_q[i] | pulse[i];
            end
            // R2: a latched reset-required bit never drops without reset
            assert_sticky_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
                acc_q[i] |=> acc_q[i]);
        end else begin : g_event
            // Restart at event start, otherwise accumulate.
            always_ff @(posedge clk) begin
                if (!rst_n)         acc_q[i] <= 1'b0;
                else if (evt_start) acc_q[i] <= pulse[i];
                else                acc_q[i] <= acc_q[i] | pulse[i];
            end
            // R3: a per-event bit with no pulse at event start reads clear after it
            assert_clear_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (evt_start && !pulse[i]) |=> !acc_q[i]);
        end
    end
endmodule

// File: rtl/errstat_in_mask.sv
// Module: errstat_in_mask
// Builds a per-event mask of inputs that raised a hit; indices at or
// above N_IN are dropped. Cleared by evt_start (hit in that cycle kept).
// Assumes: synchronous active-low reset; one index per cycle.
module errstat_in_mask #(
    parameter int N_IN  = 15,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_start,
    input  logic             hit,
    input  logic [IDX_W-1:0] idx,
    output logic [N_IN-1:0]  mask_q,
    output logic [N_IN-1:0]  mask_now
);
    logic [N_IN-1:0] hit_vec;

    // Decode the index into a one-hot hit vector.
    for (genvar k = 0; k < N_IN; k++) begin : g_dec
        assign hit_vec[k] = hit && (idx == IDX_W'(k));
    end

    // Current view including this cycle's hit, used by the snapshot.
    assign mask_now = mask_q | hit_vec;

    // Accumulate hits over the event.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (evt_start) mask_q <= hit_vec;
        else                mask_q <= mask_q | hit_vec;
    end

    // R9: an out-of-range index leaves the mask untouched
    assert_idx_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt_start && hit && (int'(idx) >= N_IN)) |=> $stable(mask_q));
    // R9: at most one new bit per cycle
    assert_one_new_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_start |=> $countones(mask_q & ~$past(mask_q)) <= 1);
endmodule

// File: rtl/errstat_summary.sv
// Module: errstat_summary
// Forms the four summary bits as ORs over the condition classes.
// Assumes: classes sit in order sticky, bad, warn, near-full, info.
module errstat_summary #(
    parameter int N_STICKY = 8,
    parameter int N_BAD    = 12,
    parameter int N_WARN   = 2,
    parameter int N_NFULL  = 2,
    parameter int N_SRC    = 28
) (
    input  logic [N_SRC-1:0] src,
    input  logic             dn_wait,
    output logic [3:0]       sum
);
    import errstat_pkg::*;
    localparam int BAD_LO = N_STICKY;
    localparam int WRN_LO = BAD_LO + N_BAD;
    localparam int NF_LO  = WRN_LO + N_WARN;

    // OR each class into its summary position.
    always_comb begin
        sum            = '0;
        sum[SUM_CRIT]  = |src[N_STICKY-1:0];
        sum[SUM_BAD]   = |src[BAD_LO +: N_BAD];
        sum[SUM_WARN]  = |src[WRN_LO +: N_WARN];
        sum[SUM_NFULL] = (|src[NF_LO +: N_NFULL]) | dn_wait;
    end
endmodule

// File: rtl/errstat_agg.sv
// Module: errstat_agg (top)
// Aggregates condition pulses and per-input hits over an event and
// captures the trailer status word and input masks on evt_end.
// Assumes: synchronous active-low reset; evt_start and evt_end are not
// asserted together (if they are, the snapshot sees the old event).
module errstat_agg #(
    parameter int N_STICKY = errstat_pkg::N_STICKY_D,
    parameter int N_BAD    = errstat_pkg::N_BAD_D,
    parameter int N_WARN   = errstat_pkg::N_WARN_D,
    parameter int N_NFULL  = errstat_pkg::N_NFULL_D,
    parameter int N_INFO   = errstat_pkg::N_INFO_D,
    parameter int N_IN     = errstat_pkg::N_IN_D,
    parameter int IDX_W    = errstat_pkg::IDX_W_D,
    localparam int N_SRC   = N_STICKY + N_BAD + N_WARN + N_NFULL + N_INFO,
    localparam int W       = N_SRC + errstat_pkg::N_SUM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_start,
    input  logic             evt_end,
    input  logic [N_SRC-1:0] src_pulse,
    input  logic             dn_wait,
    input  logic             in_err_hit,
    input  logic             in_warn_hit,
    input  logic [IDX_W-1:0] in_idx,
    output logic [W-1:0]     trl_status,
    output logic [N_IN-1:0]  in_err_mask,
    output logic [N_IN-1:0]  in_warn_mask
);
    import errstat_pkg::*;

    logic [N_SRC-1:0] acc_q, acc_now;
    logic [N_IN-1:0]  em_q, em_now, wm_q, wm_now;
    logic [3:0]       sum;

    errstat_src_accum #(.N_SRC(N_SRC), .N_STICKY(N_STICKY)) u_accum (
        .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .pulse(src_pulse),
        .acc_q(acc_q), .acc_now(acc_now));

    errstat_in_mask #(.N_IN(N_IN), .IDX_W(IDX_W)) u_err_mask (
        .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .hit(in_err_hit),
        .idx(in_idx), .mask_q(em_q), .mask_now(em_now));

    errstat_in_mask #(.N_IN(N_IN), .IDX_W(IDX_W)) u_warn_mask (
        .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .hit(in_warn_hit),
        .idx(in_idx), .mask_q(wm_q), .mask_now(wm_now));

    errstat_summary #(.N_STICKY(N_STICKY), .N_BAD(N_BAD), .N_WARN(N_WARN),
                      .N_NFULL(N_NFULL), .N_SRC(N_SRC)) u_sum (
        .src(acc_now), .dn_wait(dn_wait), .sum(sum));

    // Capture word and masks at event end, including same-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trl_status   <= '0;
            in_err_mask  <= '0;
            in_warn_mask <= '0;
        end else if (evt_end) begin
            trl_status   <= {sum, acc_now};
            in_err_mask  <= em_now;
            in_warn_mask <= wm_now;
        end
    end

    // R8: outputs hold between event ends
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_end |=> ($stable(trl_status) && $stable(in_err_mask) && $stable(in_warn_mask)));
    // R4: captured critical summary matches the captured reset-required bits
    assert_crit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_end |=> trl_status[N_SRC+SUM_CRIT] == (|trl_status[N_STICKY-1:0]));
    // R5: captured bad-event summary matches its class
    assert_bad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_end |=> trl_status[N_SRC+SUM_BAD] == (|trl_status[N_STICKY +: N_BAD]));
    // R2: a latched reset-required bit is present in every later snapshot
    assert_snap_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_end && acc_q[0]) |=> trl_status[0]);
    // R10: a mask bit seen in the end cycle is captured
    assert_mask_snap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_end && em_q[0]) |=> in_err_mask[0]);
endmodule

// File: tb/errstat_agg_tb_top.sv
// Bench: sweeps every condition bit and every input index with an
// expected-value model written from the requirements.
module errstat_agg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt_start = 1'b0, evt_end = 1'b0, dn_wait = 1'b0;
    logic [27:0] src_pulse = '0;
    logic        in_err_hit = 1'b0, in_warn_hit = 1'b0;
    logic [3:0]  in_idx = '0;
    logic [31:0] trl_status;
    logic [14:0] in_err_mask, in_warn_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Model state
    logic [27:0] m_ev, m_stk;
    logic [14:0] m_em, m_wm;
    logic [31:0] x_word;
    logic [14:0] x_em, x_wm;
    localparam logic [27:0] STK = 28'h00000FF;

    always #4 clk = ~clk;

    errstat_agg dut_i (
        .clk(clk), .rst_n(rst_n), .evt_start(evt_start), .evt_end(evt_end),
        .src_pulse(src_pulse), .dn_wait(dn_wait), .in_err_hit(in_err_hit),
        .in_warn_hit(in_warn_hit), .in_idx(in_idx), .trl_status(trl_status),
        .in_err_mask(in_err_mask), .in_warn_mask(in_warn_mask));

    function automatic logic [31:0] compose(input logic [27:0] v, input logic w);
        compose = {(|v[23:22]) | w, |v[21:20], |v[19:8], |v[7:0], v};
    endfunction

    function automatic logic [14:0] dec(input logic h, input logic [3:0] i);
        dec = (h && i < 4'd15) ? (15'd1 << i) : 15'd0;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_outs(input string req);
        chk({req, " word"}, trl_status, x_word);
        chk({req, " errmask"}, {17'd0, in_err_mask}, {17'd0, x_em});
        chk({req, " warnmask"}, {17'd0, in_warn_mask}, {17'd0, x_wm});
    endtask

    // Drive one cycle from a negedge, update the model, check after an end.
    task automatic cyc(input logic st, input logic en, input logic [27:0] s,
                       input logic eh, input logic wh, input logic [3:0] ix,
                       input logic w, input string req);
        evt_start = st; evt_end = en; src_pulse = s; in_err_hit = eh;
        in_warn_hit = wh; in_idx = ix; dn_wait = w;
        m_stk = m_stk | (s & STK);
        if (st) begin
            m_ev = s; m_em = dec(eh, ix); m_wm = dec(wh, ix);
        end else begin
            m_ev = m_ev | s; m_em = m_em | dec(eh, ix); m_wm = m_wm | dec(wh, ix);
        end
        if (en) begin
            x_word = compose((m_ev & ~STK) | m_stk, w);
            x_em = m_em; x_wm = m_wm;
        end
        @(negedge clk);
        evt_start = 0; evt_end = 0; src_pulse = '0; in_err_hit = 0;
        in_warn_hit = 0; dn_wait = 0;
        if (en) check_outs(req);
    endtask

    task automatic do_reset();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        rst_n = 1;
        m_ev = '0; m_stk = '0; m_em = '0; m_wm = '0;
        x_word = '0; x_em = '0; x_wm = '0;
    endtask

    initial begin
        do_reset();
        check_outs("R1 after reset");

        // R2 R3 R4 R5 R6 R7: each source bit alone, sticky ones accumulate
        for (int s = 0; s < 28; s++) begin
            cyc(1, 0, '0, 0, 0, 0, 0, "");
            cyc(0, 0, 28'd1 << s, 0, 0, 0, 0, "");
            cyc(0, 1, '0, 0, 0, 0, 0, "R2 R3 R4 R5 R6 R7 source sweep");
        end
        // R2: empty event still reports every latched bit
        cyc(1, 0, '0, 0, 0, 0, 0, "");
        cyc(0, 1, '0, 0, 0, 0, 0, "R2 sticky across empty event");
        chk("R2 latched set", {24'd0, trl_status[7:0]}, 32'h000000FF);

        // R3: pulse in the gap is dropped, pulse in the start cycle is kept
        cyc(0, 0, 28'd1 << 10, 0, 0, 0, 0, "");
        cyc(1, 0, 28'd1 << 12, 0, 0, 0, 0, "");
        cyc(0, 1, '0, 0, 0, 0, 0, "R3 gap and start-cycle pulses");
        chk("R3 bit12 kept bit10 dropped", {30'd0, trl_status[12], trl_status[10]}, 32'd2);

        // R7 R8: end-cycle pulse and wait level are included
        cyc(1, 0, '0, 0, 0, 0, 0, "");
        cyc(0, 1, 28'd1 << 25, 0, 0, 0, 1, "R7 R8 end-cycle pulse with wait");
        // R8: hold with activity but no end
        cyc(0, 0, 28'd1 << 9, 1, 1, 3, 1, "");
        cyc(0, 0, 28'd1 << 21, 0, 0, 0, 0, "");
        check_outs("R8 hold");

        // R1: reset clears latched bits
        do_reset();
        cyc(1, 0, '0, 0, 0, 0, 0, "");
        cyc(0, 1, '0, 0, 0, 0, 0, "R1 reset clears sticky");

        // R9 R10: every index for errors and warnings, mid-event and end cycle
        for (int i = 0; i < 16; i++) begin
            cyc(1, 0, '0, 0, 0, 0, 0, "");
            cyc(0, 0, '0, 1, 0, 4'(i), 0, "");
            cyc(0, 1, '0, 0, 1, 4'(15 - i), 0, "R9 R10 index sweep");
        end
        // R9: masks accumulate across an event then clear at next start
        cyc(1, 0, '0, 1, 1, 0, 0, "");
        cyc(0, 0, '0, 1, 0, 7, 0, "");
        cyc(0, 0, '0, 0, 1, 14, 0, "");
        cyc(0, 1, '0, 1, 0, 15, 0, "R9 accumulate and ignore 15");
        cyc(1, 0, '0, 0, 0, 0, 0, "");
        cyc(0, 1, '0, 0, 0, 0, 0, "R9 cleared at start");

        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule